// File: doc/BRIEF.md
# Phase-Accumulator PWM with Deferred Commit

This block produces one pulse-width-modulated output from a single 32-bit configuration register. The output frequency comes from a phase accumulator: each clock it adds a programmable increment, and every carry out of its top bit starts a new output period. Over one period the output is high while the accumulator's upper byte is at or above an 8-bit threshold. Because the threshold is compared as a floor, a threshold of 0 gives the widest pulse and 255 the narrowest.

Software writes new settings into a shadow copy and then raises an update request. The new increment and threshold move into the active copy only at the next period boundary, and the request bit clears itself at that moment. Software therefore polls the bit until it reads 0 before writing again. While the request is pending, writes to the increment and threshold are dropped. A disabled channel counts as permanently at a boundary, so a request made while it is stopped completes on the next clock. Software can then commit settings first and enable the output afterwards.

Top module: `pacc_pwm`

## Requirements
- R1: After reset the register reads 0x00000000, the output is low and no update is pending.
- R2: Register fields are: bit 31 enable, bit 30 update request, bits [8 +: INC_W] increment, bits 7:0 threshold. A read returns enable, the pending flag, and the shadow increment and threshold. All other bits read as 0.
- R3: While enabled, the accumulator adds the active increment every clock, modulo 2^INC_W. Each carry out starts a new output period, so with increment 0x1000 and INC_W=16 the period is 16 clocks.
- R4: The output is high exactly when the block is enabled and the upper 8 accumulator bits are greater than or equal to the active threshold.
- R5: Writing 1 to bit 30 with no update pending sets the pending flag. While enabled, the shadow settings become active at the first carry out, and the flag reads 0 from the clock after it.
- R6: While an update is pending, writes leave the shadow increment and threshold unchanged, and bit 30 in a write has no further effect.
- R7: While disabled, a pending update commits at the next clock edge, so the flag reads 1 for exactly one cycle after the request.
- R8: With enable 0 the output is low and the accumulator is held at 0. Enabling restarts the period from accumulator 0 using the last committed settings.
- R9: Writing new increment or threshold values without bit 30 changes only the shadow copy. The output keeps its active settings.
- R10: A threshold of 0 keeps the output high for the whole period. A threshold of 255 makes it high only while the upper byte is 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the configuration register |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Register readback |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions take for granted that the only writer obeys the register layout and that the increment is nonzero whenever a commit must finish while enabled. A zero increment never produces a carry, so a pending flag would stay set indefinitely, and the boundary properties depend on carries happening. The random stimulus therefore draws increments from 0x0100 upward. It also sets the reserved bits at random to check that they read back as 0. Writes land both while an update is pending and while it is not, and enable is toggled, so commits occur from both the running and the stopped state.

// File: rtl/pacc_pwm_pkg.sv
package pacc_pwm_pkg;
  localparam int EN_BIT  = 31;
  localparam int UPD_BIT = 30;
  localparam int INC_LSB = 8;
  localparam int THR_W   = 8;

  typedef logic [THR_W-1:0] thr_t;

  // Duty rule: output on when the phase byte reaches the threshold
  function automatic logic duty_on(input thr_t phase_byte, input thr_t thr);
    return phase_byte >= thr;
  endfunction

  // Period boundary: a stopped channel is always at a boundary
  function automatic logic at_boundary(input logic enabled, input logic carry);
    return !enabled || carry;
  endfunction
endpackage

// File: rtl/pacc_cfg_regs.sv
module pacc_cfg_regs
  import pacc_pwm_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_enable,
  input  logic             wr_update,
  input  logic [INC_W-1:0] wr_inc,
  input  thr_t             wr_thr,
  input  logic             boundary_i,
  output logic             en_o,
  output logic             upd_o,
  output logic [INC_W-1:0] sh_inc_o,
  output thr_t             sh_thr_o,
  output logic [INC_W-1:0] act_inc_o,
  output thr_t             act_thr_o,
  output logic             commit_o
);
  logic             en_q, upd_q;
  logic [INC_W-1:0] sh_inc_q, act_inc_q;
  thr_t             sh_thr_q, act_thr_q;
  logic             shadow_wr;

  assign commit_o  = upd_q && boundary_i;
  assign shadow_wr = wr_en && !upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      upd_q     <= 1'b0;
      sh_inc_q  <= '0;
      sh_thr_q  <= '0;
      act_inc_q <= '0;
      act_thr_q <= '0;
    end else begin
      if (wr_en) en_q <= wr_enable;
      if (commit_o) begin
        act_inc_q <= sh_inc_q;
        act_thr_q <= sh_thr_q;
        upd_q     <= 1'b0;
      end else if (shadow_wr && wr_update) begin
        upd_q <= 1'b1;
      end
      if (shadow_wr) begin
        sh_inc_q <= wr_inc;
        sh_thr_q <= wr_thr;
      end
    end
  end

  assign en_o      = en_q;
  assign upd_o     = upd_q;
  assign sh_inc_o  = sh_inc_q;
  assign sh_thr_o  = sh_thr_q;
  assign act_inc_o = act_inc_q;
  assign act_thr_o = act_thr_q;

  // R6
  shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> ($stable(sh_inc_q) && $stable(sh_thr_q)));
  // R5
  pending_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !boundary_i) |=> upd_q);
  // R7
  idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !en_q) |=> !upd_q);
  // R9
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_o |=> ($stable(act_inc_q) && $stable(act_thr_q)));
endmodule

// File: rtl/pacc_phase_acc.sv
module pacc_phase_acc #(
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [INC_W-1:0] acc_o,
  output logic             wrap_o
);
  logic [INC_W-1:0] acc_q;
  logic [INC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap_o = en_i && sum[INC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (en_i) acc_q <= sum[INC_W-1:0];
    else           acc_q <= '0;
  end

  assign acc_o = acc_q;

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (acc_q == '0));
  // R3
  wrap_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (acc_q < $past(inc_i)));
endmodule

// File: rtl/pacc_duty_cmp.sv
module pacc_duty_cmp
  import pacc_pwm_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [INC_W-1:0] acc_i,
  input  thr_t             thr_i,
  output logic             pwm_o
);
  thr_t phase_byte;

  assign phase_byte = acc_i[INC_W-1 -: THR_W];
  assign pwm_o      = en_i && duty_on(phase_byte, thr_i);

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !pwm_o);
  // R10
  full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && thr_i == '0) |-> pwm_o);
endmodule

// File: rtl/pacc_pwm.sv
module pacc_pwm
  import pacc_pwm_pkg::*;
#(
  parameter int INC_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_en,
  input  logic [31:0] bus_wr_data,
  output logic [31:0] bus_rd_data,
  output logic        pwm_out
);
  localparam int PAD_W = UPD_BIT - INC_LSB - INC_W;

  logic             en, upd, commit, wrap, boundary;
  logic [INC_W-1:0] sh_inc, act_inc, acc;
  thr_t             sh_thr, act_thr;

  generate
    if (PAD_W > 0) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^bus_wr_data[UPD_BIT-1:INC_LSB+INC_W];
    end
  endgenerate

  assign boundary = at_boundary(en, wrap);

  pacc_cfg_regs #(.INC_W(INC_W)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr_en),
    .wr_enable  (bus_wr_data[EN_BIT]),
    .wr_update  (bus_wr_data[UPD_BIT]),
    .wr_inc     (bus_wr_data[INC_LSB +: INC_W]),
    .wr_thr     (bus_wr_data[THR_W-1:0]),
    .boundary_i (boundary),
    .en_o       (en),
    .upd_o      (upd),
    .sh_inc_o   (sh_inc),
    .sh_thr_o   (sh_thr),
    .act_inc_o  (act_inc),
    .act_thr_o  (act_thr),
    .commit_o   (commit)
  );

  pacc_phase_acc #(.INC_W(INC_W)) acc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en),
    .inc_i  (act_inc),
    .acc_o  (acc),
    .wrap_o (wrap)
  );

  pacc_duty_cmp #(.INC_W(INC_W)) cmp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en),
    .acc_i (acc),
    .thr_i (act_thr),
    .pwm_o (pwm_out)
  );

  always_comb begin
    bus_rd_data                      = '0;
    bus_rd_data[EN_BIT]              = en;
    bus_rd_data[UPD_BIT]             = upd;
    bus_rd_data[INC_LSB +: INC_W]    = sh_inc;
    bus_rd_data[THR_W-1:0]           = sh_thr;
  end

  // R5
  commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !upd);
endmodule

// File: tb/pacc_pwm_tb_top.sv
`timescale 1ns/1ps
module pacc_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wr_data = '0;
  logic [31:0] bus_rd_data;
  logic        pwm_out;

  int checks = 0;
  int failures = 0;

  // bench-side model state
  logic        m_en = 0, m_upd = 0;
  logic [15:0] m_sinc = 0, m_ainc = 0, m_acc = 0;
  logic [7:0]  m_sthr = 0, m_athr = 0;

  always #2 clk = ~clk;

  pacc_pwm #(.INC_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
    .bus_rd_data(bus_rd_data), .pwm_out(pwm_out)
  );

  function automatic logic [31:0] cfg(input logic en, input logic up,
                                      input logic [15:0] inc, input logic [7:0] thr);
    return {en, up, 6'd0, inc, thr};
  endfunction

  function automatic logic exp_pwm();
    return m_en && (m_acc[15:8] >= m_athr);
  endfunction

  function automatic logic [31:0] exp_rd();
    return {m_en, m_upd, 6'd0, m_sinc, m_sthr};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic w, input logic [31:0] d);
    logic [16:0] sum;
    logic        wrp, commit, shw;
    sum    = {1'b0, m_acc} + {1'b0, m_ainc};
    wrp    = m_en && sum[16];
    commit = m_upd && (!m_en || wrp);
    shw    = w && !m_upd;
    m_acc  = m_en ? sum[15:0] : 16'd0;
    if (commit) begin m_ainc = m_sinc; m_athr = m_sthr; m_upd = 0; end
    else if (shw && d[30]) m_upd = 1;
    if (shw) begin m_sinc = d[23:8]; m_sthr = d[7:0]; end
    if (w) m_en = d[31];
  endtask

  task automatic tick(input logic w = 0, input logic [31:0] d = 0);
    bus_wr_en   = w;
    bus_wr_data = d;
    @(posedge clk);
    model_step(w, d);
    @(negedge clk);
    bus_wr_en = 0;
    chk(pwm_out === exp_pwm(), "R4 output vs model", {31'd0, pwm_out}, {31'd0, exp_pwm()});
    chk(bus_rd_data === exp_rd(), "R2 readback vs model", bus_rd_data, exp_rd());
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int highs;
    int waited;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_rd_data === 32'h0, "R1 reset readback", bus_rd_data, 32'h0);
    chk(pwm_out === 1'b0, "R1 reset output", {31'd0, pwm_out}, 32'h0);
    rst_n = 1'b1;
    tick();

    // R7 commit while disabled
    tick(1, cfg(0, 1, 16'h1000, 8'h80));
    chk(bus_rd_data[30] === 1'b1, "R7 pending after request", {31'd0, bus_rd_data[30]}, 32'h1);
    tick();
    chk(bus_rd_data[30] === 1'b0, "R7 cleared next clock", {31'd0, bus_rd_data[30]}, 32'h0);

    // R3 R4 period 16, half duty
    tick(1, cfg(1, 0, 16'h1000, 8'h80));
    highs = 0;
    for (int i = 0; i < 64; i++) begin tick(); highs += pwm_out; end
    chk(highs == 32, "R3 high count inc 0x1000 thr 0x80", highs, 32);

    // R9 shadow-only write
    tick(1, cfg(1, 0, 16'h2000, 8'h00));
    chk(bus_rd_data[23:0] === 24'h200000, "R9 shadow readback", bus_rd_data, 32'h200000);
    highs = 0;
    for (int i = 0; i < 32; i++) begin tick(); highs += pwm_out; end
    chk(highs == 16, "R9 active unchanged", highs, 16);

    // R5 commit at wrap while enabled
    tick(1, cfg(1, 1, 16'h2000, 8'h00));
    waited = 0;
    while (bus_rd_data[30] && waited < 40) begin tick(); waited++; end
    chk(waited >= 1 && waited <= 16, "R5 clear within one period", waited, 16);
    highs = 0;
    for (int i = 0; i < 16; i++) begin tick(); highs += pwm_out; end
    chk(highs == 16, "R10 threshold 0 always high", highs, 16);

    // R6 writes ignored while pending
    tick(1, cfg(1, 1, 16'h0100, 8'hFF));
    tick(1, cfg(1, 1, 16'h0800, 8'h40));
    chk(bus_rd_data[23:0] === 24'h0100FF, "R6 shadow frozen", bus_rd_data, 32'h0100FF);
    waited = 0;
    while (bus_rd_data[30] && waited < 40) begin tick(); waited++; end
    chk(bus_rd_data[30] === 1'b0, "R6 pending eventually clears", bus_rd_data, 32'h0);

    // R8 disable then fresh restart
    tick(1, cfg(0, 0, 16'h0100, 8'hFF));
    chk(pwm_out === 1'b0, "R8 output low when disabled", {31'd0, pwm_out}, 32'h0);
    tick();
    tick(1, cfg(1, 0, 16'h0100, 8'hFF));
    highs = 0;
    waited = -1;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out) begin highs++; waited = i; end
      tick();
    end
    chk(highs == 1, "R10 threshold 255 one high per period", highs, 1);
    chk(waited == 255, "R8 restart from zero phase", waited, 255);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 6) == 0) begin
        logic [31:0] d;
        d = $urandom;
        d[23:8] = 16'h0100 + 16'($urandom % 16'hFE00);
        d[31] = (($urandom % 5) != 0);
        tick(1, d);
      end else tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule